// File: doc/BRIEF.md
# Event-Selectable Performance Counter Bank

This block holds four 32-bit performance counters. Each counter has an 8-bit event selector. In every clock cycle, a counter adds one when the single-cycle strobe chosen by its selector is high. The pipeline and the memory system supply a vector of one-cycle event strobes.

The meaning of a selector byte depends on which counter it belongs to. An event code written as a five-digit hex number gives the counter in its top digit (1 to 4) and the selector in its low byte. For example, 300f0 means counter 3 with selector f0. Some events can be counted on only one counter. The same byte can pick different events on different counters. A selector byte that the map does not list for its counter counts nothing.

Software reaches the counters and selectors through a write port and a combinational read port that share one small address space. A global freeze input stops all counting but does not block register writes.

Top module: `pmc_bank`

## Requirements
- R1: The bit positions of `ev_strobe` are: 0 floating-point op done, 1 load done, 2 store done, 3 instruction-cache miss, 4 instruction TLB miss, 5 instruction TLB miss resolved, 6 data-cache load miss, 7 data-cache load miss resolved, 8 data-cache store miss, 9 data TLB miss, 10 data TLB miss resolved, 11 idle cycle (nothing available, nothing executing), 12 instruction dispatched, 13 taken branch completed, 14 branch mispredicted, 15 external interrupt taken. Counter 1 counts bit 0 with selector f4, bit 1 with fc, bit 4 with f6 and bit 11 with f8.
- R2: Counter 2 counts bit 2 with selector f0, bit 3 with fc, bit 10 with f6, bit 13 with fa and bit 15 with f8.
- R3: Counter 3 counts bit 7 with selector f8, bit 8 with f0 and bit 9 with fc.
- R4: Counter 4 counts bit 5 with selector fc, bit 6 with f0 and bit 14 with f6.
- R5: Selector f2 counts bit 12 (dispatch) on counters 2, 3 and 4. On counter 1, f2 counts nothing.
- R6: A selector value that is not mapped for its counter leaves that counter unchanged whatever the strobes are. This includes values that are mapped on another counter, and 00.
- R7: A selected strobe that is high in each of N consecutive cycles raises its counter by exactly N. The selected strobe alone causes the increment, and no other strobe does.
- R8: A counter holding all ones wraps to zero on its next increment.
- R9: While `freeze` is high, no counter increments. Register writes still take effect.
- R10: A write to a counter in the same cycle as one of its increments stores the written value.
- R11: Reset (synchronous, active high) clears all counters and all selectors to zero.
- R12: Addresses 0 to 3 are counters 1 to 4, and addresses 4 to 7 are selectors 1 to 4. A write takes effect at the next clock edge. A selector write keeps the low 8 data bits. The read port is combinational, and a selector reads back zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | Stops all counting while high |
| ev_strobe | input | 16 | One-cycle event strobes, bit map in R1 |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 3 | Write address (0-3 counters, 4-7 selectors) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address, same map as writes |
| rd_data | output | 32 | Combinational read data |

## Verification
The bench builds the block with its default parameters: four counters, 32-bit counts and 8-bit selectors. It therefore exercises the real code map and the real counter width. The write port preloads values such as all ones and all ones minus one. This reaches the 32-bit wrap in a few cycles, with no need for a narrow test build. For every mapped code and for several unmapped ones, a vector table first drives every strobe except the selected one and then the selected one alone. This shows that each selector picks exactly one event, or none.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;

    localparam int NUM_EVENTS = 16;
    localparam int EV_IDX_W   = $clog2(NUM_EVENTS);
    localparam int SEL_W      = 8;

    // Position of each strobe inside the event vector
    typedef enum logic [EV_IDX_W-1:0] {
        EV_FP_DONE    = 4'd0,
        EV_LD_DONE    = 4'd1,
        EV_ST_DONE    = 4'd2,
        EV_IC_MISS    = 4'd3,
        EV_ITLB_MISS  = 4'd4,
        EV_ITLB_FIX   = 4'd5,
        EV_DCLD_MISS  = 4'd6,
        EV_DCLD_FIX   = 4'd7,
        EV_DCST_MISS  = 4'd8,
        EV_DTLB_MISS  = 4'd9,
        EV_DTLB_FIX   = 4'd10,
        EV_IDLE_CYC   = 4'd11,
        EV_DISPATCH   = 4'd12,
        EV_BR_TAKEN   = 4'd13,
        EV_BR_MISS    = 4'd14,
        EV_EXT_IRQ    = 4'd15
    } pmc_event_e;

    // Result of resolving one (counter, selector) pair
    typedef struct packed {
        logic       valid;
        pmc_event_e ev;
    } pmc_route_t;

    // Resolve the selector of counter ctr (0-based) into an event line
    function automatic pmc_route_t pmc_route(input int ctr, input logic [SEL_W-1:0] sel);
        pmc_route_t r;
        r.valid = 1'b0;
        r.ev    = EV_FP_DONE;
        case (ctr)
            0: begin
                case (sel)
                    8'hf4: begin r.valid = 1'b1; r.ev = EV_FP_DONE;   end
                    8'hfc: begin r.valid = 1'b1; r.ev = EV_LD_DONE;   end
                    8'hf6: begin r.valid = 1'b1; r.ev = EV_ITLB_MISS; end
                    8'hf8: begin r.valid = 1'b1; r.ev = EV_IDLE_CYC;  end
                    default: ;
                endcase
            end
            1: begin
                case (sel)
                    8'hf0: begin r.valid = 1'b1; r.ev = EV_ST_DONE;   end
                    8'hfc: begin r.valid = 1'b1; r.ev = EV_IC_MISS;   end
                    8'hf6: begin r.valid = 1'b1; r.ev = EV_DTLB_FIX;  end
                    8'hfa: begin r.valid = 1'b1; r.ev = EV_BR_TAKEN;  end
                    8'hf8: begin r.valid = 1'b1; r.ev = EV_EXT_IRQ;   end
                    8'hf2: begin r.valid = 1'b1; r.ev = EV_DISPATCH;  end
                    default: ;
                endcase
            end
            2: begin
                case (sel)
                    8'hf8: begin r.valid = 1'b1; r.ev = EV_DCLD_FIX;  end
                    8'hf0: begin r.valid = 1'b1; r.ev = EV_DCST_MISS; end
                    8'hfc: begin r.valid = 1'b1; r.ev = EV_DTLB_MISS; end
                    8'hf2: begin r.valid = 1'b1; r.ev = EV_DISPATCH;  end
                    default: ;
                endcase
            end
            3: begin
                case (sel)
                    8'hfc: begin r.valid = 1'b1; r.ev = EV_ITLB_FIX;  end
                    8'hf0: begin r.valid = 1'b1; r.ev = EV_DCLD_MISS; end
                    8'hf6: begin r.valid = 1'b1; r.ev = EV_BR_MISS;   end
                    8'hf2: begin r.valid = 1'b1; r.ev = EV_DISPATCH;  end
                    default: ;
                endcase
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pmc_sel_decode.sv
`timescale 1ns/1ps
module pmc_sel_decode
    import pmc_pkg::*;
#(
    parameter int CTR_IDX = 0
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    output logic                  hit
);
    pmc_route_t route;

    always_comb begin
        route = pmc_route(CTR_IDX, sel);
        hit   = route.valid & ev_strobe[route.ev];
    end
endmodule

// File: rtl/pmc_counter.sv
`timescale 1ns/1ps
module pmc_counter #(
    parameter int CTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic             hit,
    input  logic             wr,
    input  logic [CTR_W-1:0] wr_data,
    output logic [CTR_W-1:0] count
);
    logic [CTR_W-1:0] count_q;
    logic             bump;

    assign bump  = hit & ~freeze;
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr) begin
            count_q <= wr_data;
        end else if (bump) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/pmc_bank.sv
`timescale 1ns/1ps
module pmc_bank
    import pmc_pkg::*;
#(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    localparam int IDX_W  = $clog2(NUM_CTR),
    localparam int ADDR_W = IDX_W + 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  freeze,
    input  logic [NUM_EVENTS-1:0] ev_strobe,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CTR_W-1:0]      wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [CTR_W-1:0]      rd_data
);
    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q;
    logic [NUM_CTR-1:0][SEL_W-1:0] sel_q;

    logic             wr_is_sel;
    logic [IDX_W-1:0] wr_idx;
    logic             rd_is_sel;
    logic [IDX_W-1:0] rd_idx;

    assign wr_is_sel = wr_addr[IDX_W];
    assign wr_idx    = wr_addr[IDX_W-1:0];
    assign rd_is_sel = rd_addr[IDX_W];
    assign rd_idx    = rd_addr[IDX_W-1:0];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        logic hit;
        logic ctr_wr;
        logic sel_wr;

        assign ctr_wr = wr_en & ~wr_is_sel & (wr_idx == IDX_W'(i));
        assign sel_wr = wr_en &  wr_is_sel & (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                sel_q[i] <= '0;
            end else if (sel_wr) begin
                sel_q[i] <= wr_data[SEL_W-1:0];
            end
        end

        pmc_sel_decode #(
            .CTR_IDX (i)
        ) u_dec (
            .sel       (sel_q[i]),
            .ev_strobe (ev_strobe),
            .hit       (hit)
        );

        pmc_counter #(
            .CTR_W (CTR_W)
        ) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .freeze  (freeze),
            .hit     (hit),
            .wr      (ctr_wr),
            .wr_data (wr_data),
            .count   (ctr_q[i])
        );
    end

    always_comb begin
        if (rd_is_sel) begin
            rd_data = CTR_W'(sel_q[rd_idx]);
        end else begin
            rd_data = ctr_q[rd_idx];
        end
    end
endmodule

// File: rtl/pmc_bank_chk.sv
`timescale 1ns/1ps
module pmc_bank_chk #(
    parameter int NUM_CTR = 4,
    parameter int CTR_W   = 32,
    parameter int ADDR_W  = 3
) (
    input logic                          clk,
    input logic                          rst,
    input logic                          freeze,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [CTR_W-1:0]              wr_data,
    input logic [NUM_CTR-1:0][CTR_W-1:0] ctr_q
);
    localparam int IDX_W = ADDR_W - 1;

    // R11
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctr_q == '0));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(ctr_q));

    // R10
    write_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_addr[IDX_W]) |=> (ctr_q[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)));

    for (genvar k = 0; k < NUM_CTR; k++) begin : g_step
        // R7
        single_step_chk: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> ((ctr_q[k] == $past(ctr_q[k])) ||
                        (ctr_q[k] == CTR_W'($past(ctr_q[k]) + 1'b1))));
    end
endmodule

bind pmc_bank pmc_bank_chk #(
    .NUM_CTR (NUM_CTR),
    .CTR_W   (CTR_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .freeze  (freeze),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctr_q   (ctr_q)
);

// File: tb/pmc_bank_tb.sv
`timescale 1ns/1ps
module pmc_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        freeze = 1'b0;
    logic [15:0] ev_strobe = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pmc_bank u_dut (
        .clk (clk), .rst (rst), .freeze (freeze), .ev_strobe (ev_strobe),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data)
    );

    // {counter index 0-3, selector, strobe bit, expected count after lone strobe}
    localparam int NVEC = 25;
    localparam logic [31:0] VEC [NVEC] = '{
        {8'd0, 8'hf4, 8'd0,  8'd1}, {8'd0, 8'hfc, 8'd1,  8'd1},
        {8'd0, 8'hf6, 8'd4,  8'd1}, {8'd0, 8'hf8, 8'd11, 8'd1},
        {8'd1, 8'hf0, 8'd2,  8'd1}, {8'd1, 8'hfc, 8'd3,  8'd1},
        {8'd1, 8'hf6, 8'd10, 8'd1}, {8'd1, 8'hfa, 8'd13, 8'd1},
        {8'd1, 8'hf8, 8'd15, 8'd1}, {8'd1, 8'hf2, 8'd12, 8'd1},
        {8'd2, 8'hf8, 8'd7,  8'd1}, {8'd2, 8'hf0, 8'd8,  8'd1},
        {8'd2, 8'hfc, 8'd9,  8'd1}, {8'd2, 8'hf2, 8'd12, 8'd1},
        {8'd3, 8'hfc, 8'd5,  8'd1}, {8'd3, 8'hf0, 8'd6,  8'd1},
        {8'd3, 8'hf6, 8'd14, 8'd1}, {8'd3, 8'hf2, 8'd12, 8'd1},
        {8'd0, 8'hf2, 8'd12, 8'd0}, {8'd0, 8'hf0, 8'd2,  8'd0},
        {8'd1, 8'hf4, 8'd0,  8'd0}, {8'd2, 8'hf4, 8'd0,  8'd0},
        {8'd3, 8'hf8, 8'd7,  8'd0}, {8'd0, 8'h00, 8'd0,  8'd0},
        {8'd3, 8'hff, 8'd14, 8'd0}
    };

    function automatic string tag_of(input int ctr, input logic [7:0] sel, input logic [7:0] expv);
        if (expv == 0)   return "R6";
        if (sel == 8'hf2) return "R5";
        case (ctr)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse(input logic [15:0] ev, input int cycles);
        @(negedge clk);
        ev_strobe = ev;
        for (int c = 0; c < cycles; c++) @(negedge clk);
        ev_strobe = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        rd_addr = 3'(a);
        #1;
        v = rd_data;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state of all counters and selectors
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check("R11 reset", v, 32'h0);
        end

        // Table walk: R1..R6
        for (int i = 0; i < NVEC; i++) begin
            int          ctr;
            logic [7:0]  sel;
            logic [7:0]  bitp;
            logic [7:0]  expv;
            logic [15:0] lone;
            ctr  = int'(VEC[i][31:24]);
            sel  = VEC[i][23:16];
            bitp = VEC[i][15:8];
            expv = VEC[i][7:0];
            lone = 16'h1 << bitp;
            wr(ctr, 32'h0);
            wr(4 + ctr, {24'h0, sel});
            pulse(~lone, 1);
            rd(ctr, v);
            check(tag_of(ctr, sel, expv), v, 32'h0);
            pulse(lone, 1);
            rd(ctr, v);
            check(tag_of(ctr, sel, expv), v, {24'h0, expv});
        end

        // R7: five consecutive cycles on counter 1 (sel f4, bit 0)
        wr(0, 32'h0);
        wr(4, 32'hf4);
        pulse(16'h0001, 5);
        rd(0, v);
        check("R7 consecutive", v, 32'd5);

        // R8: approach and cross the wrap
        wr(0, 32'hffff_fffe);
        pulse(16'h0001, 1);
        rd(0, v);
        check("R8 to all ones", v, 32'hffff_ffff);
        pulse(16'h0001, 1);
        rd(0, v);
        check("R8 wrap", v, 32'h0);

        // R9: freeze blocks counting, not writes
        freeze = 1'b1;
        pulse(16'hffff, 3);
        rd(0, v);
        check("R9 frozen", v, 32'h0);
        wr(0, 32'd77);
        rd(0, v);
        check("R9 write under freeze", v, 32'd77);
        freeze = 1'b0;
        pulse(16'h0001, 1);
        rd(0, v);
        check("R9 thawed", v, 32'd78);

        // R10: write and increment in the same cycle
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 32'd100; ev_strobe = 16'h0001;
        @(negedge clk);
        wr_en = 1'b0; ev_strobe = '0;
        rd(0, v);
        check("R10 write wins", v, 32'd100);

        // R12: selector write keeps low byte, reads zero-extended; write timing
        wr(5, 32'h1234_56fa);
        rd(5, v);
        check("R12 selector readback", v, 32'h0000_00fa);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd3; wr_data = 32'hdead_beef;
        rd(3, v);
        check("R12 write not yet visible", v, 32'h0);
        @(negedge clk);
        wr_en = 1'b0;
        rd(3, v);
        check("R12 write visible", v, 32'hdead_beef);

        // R11: reset clears nonzero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(3, v);
        check("R11 counter cleared", v, 32'h0);
        rd(5, v);
        check("R11 selector cleared", v, 32'h0);

        done = 1'b1;
        summary();
    end
endmodule